// File: doc/BRIEF.md
# UART Receive Register Front-End

This block sits between an 8-bit memory-mapped register bus and an external UART receiver PHY. Software turns the receiver on and off through a control bit, programs a 16-bit PHY configuration word (typically a baud divisor) while the receiver is off, polls a status byte, and pulls received symbols out of a small internal buffer through a data register.

On the PHY side the block drives a reset and the configuration word. It takes received symbols over a valid/ready stream. It also takes two single-cycle pulses, one for a symbol that arrived before the previous one was taken and one for any PHY-specific fault. These pulses set sticky status flags, and software clears them by writing a one to the flag's bit.

Byte offsets on the bus: 0 control, 1 status, 2 data, 4 configuration low byte, 5 configuration high byte. Reads of other offsets return 0, and writes to them do nothing.

Top module: `uart_rx_regs`

## Requirements
- R1: Control register (offset 0): bit 0 is the enable, which resets to 0. Bits 7..1 always read 0, and writes to those bits have no effect.
- R2: `phy_rst` is 1 whenever enable is 0 and 0 whenever enable is 1.
- R3: The configuration word resets to parameter `CFG_INIT`. A write to offset 4 stages the low byte. A write to offset 5 commits {high byte, staged low byte} to `phy_cfg`. Writes to offsets 4 and 5 are ignored while enable is 1. Reads of offsets 4 and 5 return the committed low and high bytes.
- R4: Status bit 0 (read-only) is 1 exactly when the receive buffer holds at least one symbol.
- R5: Status bit 1 (overflow) resets to 0. It is set by a `phy_overflow` pulse, stays set, and is cleared by writing status with bit 1 = 1. Writing 0 to bit 1 leaves it unchanged.
- R6: Status bit 2 (error) behaves the same way, driven by `phy_error` and cleared by writing bit 2 = 1. Status bits 7..3 read 0.
- R7: Clearing enable leaves the overflow and error flags unchanged.
- R8: `sym_ready` is 1 when enable is 1 and the 4-entry buffer is not full. A symbol is stored on each cycle where `sym_valid` and `sym_ready` are both 1.
- R9: A read of offset 2 while enabled and the buffer is non-empty returns the oldest stored symbol and removes it. Symbols leave in arrival order.
- R10: A read of offset 2 while the buffer is empty does not change the buffer or the status.
- R11: While enable is 0 the buffer is emptied, so status bit 0 reads 0.
- R12: Read data appears on `bus_rdata` in the cycle after the cycle in which `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| phy_rst | output | 1 | Reset to the receiver PHY |
| phy_cfg | output | 16 | Configuration word to the PHY |
| sym_data | input | SYM_W | Received symbol |
| sym_valid | input | 1 | Symbol valid |
| sym_ready | output | 1 | Block can accept a symbol |
| phy_overflow | input | 1 | One-cycle overflow pulse |
| phy_error | input | 1 | One-cycle fault pulse |

## Verification
A register write takes effect at the clock edge that samples it. The resulting enable, `phy_rst`, `phy_cfg`, `sym_ready` and status changes can therefore be seen at the falling edge that follows. A read's data is registered at the sampling edge and is checked at the next falling edge, one cycle after the strobe. Symbols and PHY pulses are driven at a falling edge and are taken at the next rising edge. Each bus task drives at a falling edge and samples only at falling edges, so every check lands on the cycle in which its result is due.

// File: rtl/uart_rx_regs_pkg.sv
package uart_rx_regs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_STAT   = 3'd1;
  localparam logic [2:0] OFS_DATA   = 3'd2;
  localparam logic [2:0] OFS_CFG_LO = 3'd4;
  localparam logic [2:0] OFS_CFG_HI = 3'd5;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_ERR = 1;
  localparam int N_FLAGS  = 2;
endpackage

// File: rtl/rx_sym_fifo.sv
module rx_sym_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
  // R8
  push_room_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst) clr |=> empty);
endmodule

// File: rtl/rx_cfg_reg.sv
module rx_cfg_reg #(
  parameter int          BW   = 8,
  parameter logic [15:0] INIT = 16'h0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lock,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [BW-1:0]   wdata,
  output logic [2*BW-1:0] cfg
);
  logic [BW-1:0] stage_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo <= INIT[BW-1:0];
      cfg      <= (2*BW)'(INIT);
    end else if (!lock) begin
      if (wr_lo) stage_lo <= wdata;
      if (wr_hi) cfg      <= {wdata, stage_lo};
    end
  end

  // R3
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (lock && $past(lock)) |-> $stable(cfg));
endmodule

// File: rtl/rx_err_flags.sv
module rx_err_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end

    // R5 R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst) set[i] |=> flag[i]);
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!set[i] && !clr[i]) |=> (flag[i] == $past(flag[i])));
  end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_regs_pkg::*;
#(
  parameter int          ADDR_W   = 3,
  parameter int          SYM_W    = 8,
  parameter int          DEPTH    = 4,
  parameter logic [15:0] CFG_INIT = 16'h0036
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              phy_rst,
  output logic [15:0]       phy_cfg,
  input  logic [SYM_W-1:0]  sym_data,
  input  logic              sym_valid,
  output logic              sym_ready,
  input  logic              phy_overflow,
  input  logic              phy_error
);
  logic             enable_q;
  logic             fifo_empty, fifo_full, push, pop;
  logic [SYM_W-1:0] fifo_dout;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flags;
  logic             hit_ctrl, hit_stat, hit_data, hit_lo, hit_hi;
  logic [7:0]       rd_mux;

  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign hit_lo   = (bus_addr == ADDR_W'(OFS_CFG_LO));
  assign hit_hi   = (bus_addr == ADDR_W'(OFS_CFG_HI));

  always_ff @(posedge clk) begin
    if (rst)                       enable_q <= 1'b0;
    else if (bus_wr && hit_ctrl)   enable_q <= bus_wdata[0];
  end

  assign phy_rst   = ~enable_q;
  assign sym_ready = enable_q & ~fifo_full;
  assign push      = sym_valid & sym_ready;
  assign pop       = bus_rd & hit_data & enable_q & ~fifo_empty;

  rx_sym_fifo #(.W(SYM_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(~enable_q),
    .push(push), .din(sym_data), .pop(pop),
    .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
  );

  rx_cfg_reg #(.BW(BYTE_W), .INIT(CFG_INIT)) u_cfg (
    .clk(clk), .rst(rst), .lock(enable_q),
    .wr_lo(bus_wr & hit_lo), .wr_hi(bus_wr & hit_hi),
    .wdata(bus_wdata), .cfg(phy_cfg)
  );

  assign flag_set[FLAG_OVF] = phy_overflow;
  assign flag_set[FLAG_ERR] = phy_error;
  assign flag_clr[FLAG_OVF] = bus_wr & hit_stat & bus_wdata[1];
  assign flag_clr[FLAG_ERR] = bus_wr & hit_stat & bus_wdata[2];

  rx_err_flags #(.N(N_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr), .flag(flags)
  );

  always_comb begin
    rd_mux = 8'h00;
    if (hit_ctrl)      rd_mux = {7'b0, enable_q};
    else if (hit_stat) rd_mux = {5'b0, flags[FLAG_ERR], flags[FLAG_OVF], ~fifo_empty};
    else if (hit_data) rd_mux = 8'(fifo_dout);
    else if (hit_lo)   rd_mux = phy_cfg[7:0];
    else if (hit_hi)   rd_mux = phy_cfg[15:8];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R2
  ready_needs_run_chk: assert property (@(posedge clk) disable iff (rst) sym_ready |-> !phy_rst);
  // R11
  idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(phy_rst) && phy_rst) |-> !sym_ready);
  // R3
  cfg_run_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!phy_rst && $past(!phy_rst)) |-> $stable(phy_cfg));
endmodule

// File: tb/tb_uart_rx_regs.sv
module tb_uart_rx_regs;
  logic       clk = 0, rst = 1;
  logic [2:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       phy_rst, sym_ready;
  logic [15:0] phy_cfg;
  logic [7:0] sym_data = 0;
  logic       sym_valid = 0, phy_overflow = 0, phy_error = 0;

  int checks = 0, failures = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  uart_rx_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .phy_rst(phy_rst), .phy_cfg(phy_cfg),
    .sym_data(sym_data), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .phy_overflow(phy_overflow), .phy_error(phy_error)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] s);
    @(negedge clk); sym_data = s; sym_valid = 1;
    @(negedge clk); sym_valid = 0;
  endtask

  // op: 0 write, 1 read+check, 2 push symbol
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {2'd1, 4'd1,  3'd0, 8'h00, 8'h00},
    {2'd1, 4'd3,  3'd4, 8'h00, 8'h36},
    {2'd1, 4'd3,  3'd5, 8'h00, 8'h00},
    {2'd0, 4'd1,  3'd0, 8'hFF, 8'h00},
    {2'd1, 4'd1,  3'd0, 8'h00, 8'h01},
    {2'd1, 4'd4,  3'd1, 8'h00, 8'h00},
    {2'd2, 4'd8,  3'd0, 8'h41, 8'h00},
    {2'd2, 4'd8,  3'd0, 8'h42, 8'h00},
    {2'd1, 4'd4,  3'd1, 8'h00, 8'h01},
    {2'd1, 4'd9,  3'd2, 8'h00, 8'h41},
    {2'd1, 4'd9,  3'd2, 8'h00, 8'h42},
    {2'd1, 4'd4,  3'd1, 8'h00, 8'h00},
    {2'd1, 4'd12, 3'd3, 8'h00, 8'h00},
    {2'd0, 4'd1,  3'd0, 8'h00, 8'h00}
  };

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    check("R2 reset phy_rst", {15'b0, phy_rst}, 16'd1);
    check("R3 reset cfg", phy_cfg, 16'h0036);
    check("R8 reset ready", {15'b0, sym_ready}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][24:23])
        2'd0: wr(VEC[i][18:16], VEC[i][15:8]);
        2'd1: begin
          rd(VEC[i][18:16], rv);
          check($sformatf("R%0d table step %0d", VEC[i][22:19], i), {8'h0, rv}, {8'h0, VEC[i][7:0]});
        end
        default: push(VEC[i][15:8]);
      endcase
    end

    // R3 staged configuration write while disabled
    wr(3'd4, 8'h34);
    check("R3 low staged only", phy_cfg, 16'h0036);
    wr(3'd5, 8'h12);
    check("R3 commit on high", phy_cfg, 16'h1234);
    rd(3'd4, rv); check("R3 read low", {8'h0, rv}, 16'h0034);
    rd(3'd5, rv); check("R3 read high", {8'h0, rv}, 16'h0012);

    // R1 upper bits ignored; R2 phy_rst follows enable
    wr(3'd0, 8'hFE);
    rd(3'd0, rv); check("R1 upper bits ignored", {8'h0, rv}, 16'h0000);
    check("R2 phy_rst when off", {15'b0, phy_rst}, 16'd1);
    wr(3'd0, 8'h01);
    check("R2 phy_rst when on", {15'b0, phy_rst}, 16'd0);

    // R3 lock while enabled
    wr(3'd4, 8'hAA); wr(3'd5, 8'hBB);
    check("R3 locked", phy_cfg, 16'h1234);

    // R10 empty data read has no side effect
    rd(3'd2, rv);
    rd(3'd1, rv); check("R10 status after empty read", {8'h0, rv}, 16'h0000);
    push(8'h77);
    rd(3'd2, rv); check("R10 pointer intact", {8'h0, rv}, 16'h0077);

    // R8 fill the buffer
    for (int k = 0; k < 4; k++) push(8'h10 + 8'(k));
    check("R8 ready low when full", {15'b0, sym_ready}, 16'd0);
    push(8'hEE); // not accepted
    rd(3'd2, rv); check("R9 oldest first", {8'h0, rv}, 16'h0010);
    check("R8 ready after pop", {15'b0, sym_ready}, 16'd1);
    rd(3'd2, rv); check("R9 order", {8'h0, rv}, 16'h0011);
    rd(3'd2, rv); check("R9 order", {8'h0, rv}, 16'h0012);
    rd(3'd2, rv); check("R8 refused while full", {8'h0, rv}, 16'h0013);
    rd(3'd1, rv); check("R4 ready clear when drained", {8'h0, rv}, 16'h0000);

    // R5 R6 sticky flags
    @(negedge clk); phy_overflow = 1;
    @(negedge clk); phy_overflow = 0; phy_error = 1;
    @(negedge clk); phy_error = 0;
    repeat (2) @(negedge clk);
    rd(3'd1, rv); check("R5 R6 flags sticky", {8'h0, rv}, 16'h0006);
    wr(3'd1, 8'h00);
    rd(3'd1, rv); check("R5 write zero keeps", {8'h0, rv}, 16'h0006);

    // R7 R11 disable keeps flags, flushes buffer
    push(8'h55);
    rd(3'd1, rv); check("R4 ready set", {8'h0, rv}, 16'h0007);
    wr(3'd0, 8'h00);
    rd(3'd1, rv); check("R7 R11 flags kept, buffer flushed", {8'h0, rv}, 16'h0006);
    push(8'h66);
    rd(3'd1, rv); check("R11 no capture while off", {8'h0, rv}, 16'h0006);

    wr(3'd1, 8'h02);
    rd(3'd1, rv); check("R5 clear overflow only", {8'h0, rv}, 16'h0004);
    wr(3'd1, 8'h04);
    rd(3'd1, rv); check("R6 clear error", {8'h0, rv}, 16'h0000);

    // R12 data due exactly one cycle after strobe
    @(negedge clk); bus_addr = 3'd4; bus_rd = 1;
    @(negedge clk); bus_rd = 0; bus_addr = 3'd0;
    check("R12 one-cycle latency", {8'h0, bus_rdata}, 16'h0034);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule